// File: doc/BRIEF.md
# Load-Use Stall and Early Branch Flush Control

This block is the hazard controller of a five-stage in-order pipeline. It runs in the decode stage. It looks at the two source register fields of the instruction held in the fetch/decode register. It compares them with the destination of a load that currently sits in the decode/execute register. When the decode instruction needs a value that the load has not yet produced, the block stalls the front end for exactly one cycle. During that cycle it holds the program counter, holds the fetch/decode register, and clears every control bit that would enter the decode/execute register. The cleared bits act as a no-operation bubble. After that cycle, the ordinary write-back forwarding path supplies the loaded value.

The block also resolves branch-if-equal in decode. It XORs the two operand values bit by bit and OR-reduces the result, so no ALU is involved. When the branch is taken, it flushes only the fetch/decode register. The cost is a single cycle, and fetch continues down the fall-through path by default. When a stall and a taken branch occur in the same cycle, the stall wins. The branch is then evaluated again in the following cycle, once its operands are settled. All pins are plain level signals. The block has no streaming interface and applies no back-pressure of its own. The stall is the only hold it imposes on its neighbours.

Top module: `lu_br_hazard`

## Requirements
- R1: `stall` is 1 when `ld_pending` is 1, the previous cycle did not stall, and `ld_dest` equals `dec_src_a` or `dec_src_b`.
- R2: `stall` is 0 when `ld_pending` is 0, or when `ld_dest` matches neither source field.
- R3: While `stall` is 1, `ctrl_out` is all zeros; otherwise `ctrl_out` equals `ctrl_in`.
- R4: `pc_we` and `fd_we` are both 0 while `stall` is 1, and both 1 otherwise.
- R5: `br_taken` is 1 exactly when `is_beq` is 1, `opnd_a` equals `opnd_b` on every bit, and `stall` is 0. A difference in any single bit gives 0.
- R6: `fd_flush` equals `br_taken`: only the fetch/decode register is flushed. The PC and fetch/decode write enables stay 1 during a flush.
- R7: When a stall and a taken branch coincide, `fd_flush` is 0. If the inputs are held, the flush is raised in the following cycle.
- R8: A stall never lasts two consecutive cycles. The cycle after a stall has `stall` = 0 even if the match persists. If the match is still held in the cycle after that, a new stall is raised.
- R9: While `rst_n` is 0 the stall history is cleared. With idle inputs, the outputs are `pc_we` = 1, `fd_we` = 1, `fd_flush` = 0 and `stall` = 0. A matching load in the first cycle after reset stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_pending | input | 1 | Instruction in decode/execute reads memory |
| ld_dest | input | REG_AW | Destination register of that load |
| dec_src_a | input | REG_AW | First source field of the decode instruction |
| dec_src_b | input | REG_AW | Second source field of the decode instruction |
| is_beq | input | 1 | Decode instruction is branch-if-equal |
| opnd_a | input | DATA_W | First branch operand value |
| opnd_b | input | DATA_W | Second branch operand value |
| ctrl_in | input | CTRL_W | Decoded control bits headed for decode/execute |
| ctrl_out | output | CTRL_W | Control bits actually written into decode/execute |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| fd_flush | output | 1 | Clear fetch/decode register |
| br_taken | output | 1 | Branch-if-equal resolved taken in decode |
| stall | output | 1 | Load-use bubble inserted this cycle |

## Verification
The bench builds the block with a 16-bit operand path, 5-bit register fields and 8 control bits. The narrow operand width makes a sweep that flips each operand bit in turn exhaustive: every XOR lane and every OR-tree input is shown to break equality on its own. The 8-bit control word is small enough that alternating patterns check each bit of the bubble gate for both clearing and passing through. Register fields keep their full 5-bit width, so matches on either source field and near-miss values are covered directly.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_STALL = 2'd1,
    HZ_FLUSH = 2'd2
  } hz_action_e;

endpackage

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_pending,
  input  logic [REG_AW-1:0] ld_dest,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  output logic              stall_req
);

  logic hit_a, hit_b, stalled_q;

  assign hit_a     = (ld_dest == dec_src_a);
  assign hit_b     = (ld_dest == dec_src_b);
  // the previous cycle already bubbled: the load has moved on
  assign stall_req = ld_pending && (hit_a || hit_b) && !stalled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall_req;
  end

  // R8: never two bubbles back to back
  p_single_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> !stall_req);

  // R1: a matching load with no preceding bubble must stall
  p_detect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pending && (dec_src_a == ld_dest) && !stalled_q) |-> stall_req);

  // R2: no pending load means no stall
  p_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_pending |-> !stall_req);

endmodule

// File: rtl/hzd_eq_cmp.sv
module hzd_eq_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              equal
);

  localparam int LVLS = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int PADW = 1 << LVLS;

  logic [PADW-1:0] diff;
  logic [PADW-1:0] tree [LVLS+1];

  genvar i, l;
  generate
    for (i = 0; i < PADW; i++) begin : g_xor
      if (i < DATA_W) begin : g_live
        assign diff[i] = a[i] ^ b[i];
      end else begin : g_pad
        assign diff[i] = 1'b0;
      end
    end

    assign tree[0] = diff;
    for (l = 0; l < LVLS; l++) begin : g_lvl
      localparam int N = PADW >> (l + 1);
      for (i = 0; i < PADW; i++) begin : g_node
        if (i < N) begin : g_or
          assign tree[l+1][i] = tree[l][2*i] | tree[l][2*i+1];
        end else begin : g_zero
          assign tree[l+1][i] = 1'b0;
        end
      end
    end
  endgenerate

  assign equal = !tree[LVLS][0];

endmodule

// File: rtl/hzd_arbiter.sv
module hzd_arbiter
  import hzd_pkg::*;
(
  input  logic       stall_req,
  input  logic       is_beq,
  input  logic       equal,
  output hz_action_e action,
  output logic       pc_we,
  output logic       fd_we,
  output logic       fd_flush,
  output logic       br_taken
);

  always_comb begin
    if (stall_req)           action = HZ_STALL;
    else if (is_beq && equal) action = HZ_FLUSH;
    else                     action = HZ_NONE;
  end

  always_comb begin
    pc_we    = 1'b1;
    fd_we    = 1'b1;
    fd_flush = 1'b0;
    br_taken = 1'b0;
    unique case (action)
      HZ_STALL: begin
        pc_we = 1'b0;
        fd_we = 1'b0;
      end
      HZ_FLUSH: begin
        fd_flush = 1'b1;
        br_taken = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hzd_ctrl_gate.sv
module hzd_ctrl_gate #(
  parameter int CTRL_W = 9
) (
  input  logic              bubble,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out
);

  genvar i;
  generate
    for (i = 0; i < CTRL_W; i++) begin : g_bit
      assign ctrl_out[i] = ctrl_in[i] & ~bubble;
    end
  endgenerate

endmodule

// File: rtl/lu_br_hazard.sv
module lu_br_hazard #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_pending,
  input  logic [REG_AW-1:0] ld_dest,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic              is_beq,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              pc_we,
  output logic              fd_we,
  output logic              fd_flush,
  output logic              br_taken,
  output logic              stall
);
  import hzd_pkg::*;

  logic       stall_req, ops_equal;
  hz_action_e action;

  hzd_loaduse #(.REG_AW(REG_AW)) u_loaduse (
    .clk(clk), .rst_n(rst_n), .ld_pending(ld_pending), .ld_dest(ld_dest),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .stall_req(stall_req)
  );

  hzd_eq_cmp #(.DATA_W(DATA_W)) u_eq (
    .a(opnd_a), .b(opnd_b), .equal(ops_equal)
  );

  hzd_arbiter u_arb (
    .stall_req(stall_req), .is_beq(is_beq), .equal(ops_equal),
    .action(action), .pc_we(pc_we), .fd_we(fd_we),
    .fd_flush(fd_flush), .br_taken(br_taken)
  );

  hzd_ctrl_gate #(.CTRL_W(CTRL_W)) u_gate (
    .bubble(stall_req), .ctrl_in(ctrl_in), .ctrl_out(ctrl_out)
  );

  assign stall = stall_req;

  // R3: a bubble carries no control bits
  p_bubble_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ctrl_out == '0));

  // R4: stall freezes PC and fetch/decode register
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !fd_we));

  // R6: a flush needs a real branch with equal operands, and leaves fetch running
  p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fd_flush |-> (is_beq && opnd_a == opnd_b && pc_we && fd_we));

  // R7: stall has priority over flush
  p_stall_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !fd_flush);

  // R7: held taken branch flushes the cycle after a conflicting stall
  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && is_beq && opnd_a == opnd_b) ##1 ($stable(opnd_a) && $stable(opnd_b) && is_beq)
      |-> fd_flush);

endmodule

// File: tb/lu_br_hazard_bench.sv
`timescale 1ns/1ps
module lu_br_hazard_bench;

  localparam int AW = 5;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_pending = 1'b0;
  logic [AW-1:0] ld_dest = '0, dec_src_a = '0, dec_src_b = '0;
  logic          is_beq = 1'b0;
  logic [DW-1:0] opnd_a = '0, opnd_b = '0;
  logic [CW-1:0] ctrl_in = '0;
  logic [CW-1:0] ctrl_out;
  logic          pc_we, fd_we, fd_flush, br_taken, stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lu_br_hazard #(.REG_AW(AW), .DATA_W(DW), .CTRL_W(CW)) u_lu_br_hazard (
    .clk(clk), .rst_n(rst_n), .ld_pending(ld_pending), .ld_dest(ld_dest),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .is_beq(is_beq),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ctrl_in(ctrl_in), .ctrl_out(ctrl_out),
    .pc_we(pc_we), .fd_we(fd_we), .fd_flush(fd_flush), .br_taken(br_taken),
    .stall(stall)
  );

  // vector table: load, dest, srcA, srcB, beq, opA, opB, ctrl, expected stall, expected flush
  localparam logic          V_LD  [NV] = '{1, 1, 0, 1, 0, 0, 0, 1};
  localparam logic [AW-1:0] V_DST [NV] = '{3, 7, 3, 4, 0, 0, 0, 9};
  localparam logic [AW-1:0] V_SA  [NV] = '{3, 2, 3, 5, 1, 1, 1, 9};
  localparam logic [AW-1:0] V_SB  [NV] = '{7, 7, 3, 6, 2, 2, 2, 0};
  localparam logic          V_BQ  [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};
  localparam logic [DW-1:0] V_OA  [NV] = '{16'h0, 16'h0, 16'h1, 16'h2, 16'h1234, 16'h1234, 16'h55AA, 16'hBEEF};
  localparam logic [DW-1:0] V_OB  [NV] = '{16'h0, 16'h0, 16'h2, 16'h3, 16'h1234, 16'h1235, 16'h55AA, 16'hBEEF};
  localparam logic [CW-1:0] V_CT  [NV] = '{8'hA5, 8'h5A, 8'hFF, 8'h3C, 8'hC3, 8'h0F, 8'hF0, 8'h99};
  localparam logic          V_XS  [NV] = '{1, 1, 0, 0, 0, 0, 0, 1};
  localparam logic          V_XF  [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam string         V_TAG [NV] = '{"R1", "R1", "R2", "R2", "R6", "R5", "R5", "R7"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ld_pending = 1'b0; ld_dest = '0; dec_src_a = '0; dec_src_b = '0;
    is_beq = 1'b0; opnd_a = '0; opnd_b = '0; ctrl_in = '0;
  endtask

  task automatic check_outputs(input string tag, input logic xs, input logic xf,
                               input logic [CW-1:0] ct);
    chk({tag, " stall"}, stall, xs);
    chk({tag, " flush"}, fd_flush, xf);
    chk({tag, " taken"}, br_taken, xf);
    chk({tag, " pc_we R4"}, pc_we, !xs);
    chk({tag, " fd_we R4"}, fd_we, !xs);
    chk({tag, " ctrl R3"}, ctrl_out, xs ? '0 : ct);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    // R9: reset state with idle inputs
    repeat (3) @(negedge clk);
    #1;
    check_outputs("R9 reset", 1'b0, 1'b0, '0);

    // R9: matching load during reset still blocked? first cycle after reset stalls
    @(negedge clk);
    rst_n = 1'b1;
    ld_pending = 1'b1; ld_dest = 5'd12; dec_src_a = 5'd12; ctrl_in = 8'h77;
    #1;
    check_outputs("R9 first", 1'b1, 1'b0, 8'h77);
    @(negedge clk); idle();

    // table walk, with an idle cycle between entries
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ld_pending = V_LD[i]; ld_dest = V_DST[i]; dec_src_a = V_SA[i]; dec_src_b = V_SB[i];
      is_beq = V_BQ[i]; opnd_a = V_OA[i]; opnd_b = V_OB[i]; ctrl_in = V_CT[i];
      #1;
      check_outputs(V_TAG[i], V_XS[i], V_XF[i], V_CT[i]);
      @(negedge clk); idle();
    end

    // R8: held match stalls, releases, then stalls again
    @(negedge clk);
    ld_pending = 1'b1; ld_dest = 5'd20; dec_src_b = 5'd20; ctrl_in = 8'hE1;
    #1; check_outputs("R8 c0", 1'b1, 1'b0, 8'hE1);
    @(negedge clk); #1; check_outputs("R8 c1", 1'b0, 1'b0, 8'hE1);
    @(negedge clk); #1; check_outputs("R8 c2", 1'b1, 1'b0, 8'hE1);
    @(negedge clk); idle();

    // R7: stall hides a taken branch, flush follows when held
    @(negedge clk);
    ld_pending = 1'b1; ld_dest = 5'd6; dec_src_a = 5'd6;
    is_beq = 1'b1; opnd_a = 16'h4321; opnd_b = 16'h4321; ctrl_in = 8'h18;
    #1; check_outputs("R7 stalled", 1'b1, 1'b0, 8'h18);
    @(negedge clk); #1; check_outputs("R7 retry", 1'b0, 1'b1, 8'h18);
    @(negedge clk); idle();

    // R5: every single-bit difference breaks equality
    for (int b = 0; b < DW; b++) begin
      @(negedge clk);
      is_beq = 1'b1; opnd_a = 16'hA55A; opnd_b = 16'hA55A ^ (16'h1 << b);
      #1;
      chk($sformatf("R5 bit %0d", b), br_taken, 1'b0);
    end
    @(negedge clk);
    is_beq = 1'b1; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF;
    #1; chk("R5 all ones equal", br_taken, 1'b1);
    chk("R6 flush with all ones", fd_flush, 1'b1);
    @(negedge clk); idle();

    // R2: near-miss register fields with load pending
    @(negedge clk);
    ld_pending = 1'b1; ld_dest = 5'd16; dec_src_a = 5'd17; dec_src_b = 5'd0;
    #1; chk("R2 near miss", stall, 1'b0);
    @(negedge clk); idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule